// File: doc/BRIEF.md
# Block Stream Flow Controller

This block sits at the image-sample port of a codec that works on 8x8 blocks of 64 samples. In encode mode a sender delivers blocks into it. Each block is announced by a one-cycle sync pulse and followed by 64 samples on consecutive cycles. The controller tracks where the sender is inside each block and flags a sync that cuts a block short. When the downstream coefficient buffers report full at a fixed point inside the block, it raises a stop output 42 cycles ahead of the block's final sample. That stop warns the sender to hold back the next block. The stop is also held high whenever the port is idle or busy with configuration.

In decode mode the controller paces outgoing blocks. After a start pulse it emits a sync, then 64 sample-valid cycles, and continues block after block until the configured block count is reached. The final sample carries an end-of-scan flag and is not followed by a sync. An external stop seen 24 cycles before a block's last sample parks the output after that block. Once the stop is released, the next sync appears 17 cycles later.

In both modes a 2-bit tag names the component of the current block. A per-component block count advances the tag at every sync, and the tag reads 3 when the port is idle.

Top module: `blkstream_flow`

## Requirements
- R1: In encode mode with `run` high, `in_sync` starts a 64-sample block whose sample index 0 is on the input the cycle after the sync. A sync that arrives while a block holds only samples 0..62 pulses `sync_err` high for exactly the next cycle. A sync arriving in the same cycle as sample 63, or after the block, leaves `sync_err` low.
- R2: In encode mode, if `buf_full` is high in the cycle that carries sample index 20, then `enc_stop` is high from the cycle that carries sample index 21 (42 cycles before sample 63). It stays high while `buf_full` stays high and drops the cycle after `buf_full` is seen low.
- R3: In encode mode, `buf_full` that rises after the sample-20 cycle of a block does not raise `enc_stop` for that block.
- R4: In encode mode, `enc_stop` is high one cycle after `run` is low or `cfg_busy` is high. In decode mode `enc_stop` is low.
- R5: In decode mode with `run` high, a `dec_start` pulse while idle puts a one-cycle `out_sync` on the next cycle, followed by 64 cycles of `out_valid`. Without a stop, the next block's sync follows in the cycle after sample 63.
- R6: In decode mode, if `ext_stop` is high in the cycle that outputs sample index 39 (24 cycles before sample 63), no sync follows that block while `ext_stop` stays high. The next `out_sync` appears 17 cycles after the first cycle in which `ext_stop` is low. A stop first raised after sample 39 does not delay the next block.
- R7: In decode mode, `out_eos` is high together with sample 63 of block number `dec_nblk`, and no sync follows it. A `dec_nblk` of 0 is treated as 1.
- R8: `comp_blocks` holds one 3-bit block count per component, with component i in bits [3i+2:3i]. Components with a count of 0 are skipped, and the order wraps from 3 back to the first present component. At each sync (an accepted `in_sync` in encode mode, `out_sync` in decode mode), `comp_tag` shows the component of the new block from the following cycle onward.
- R9: `comp_tag` reads 2'b11 in the cycle after `run` is low, and the component order restarts at the first present component.
- R10: End-of-scan ends the scan and sets `comp_tag` to 2'b11 on the following cycle until the next sync. In encode mode this happens when `in_eos` is given with the last sample, even while `enc_stop` is high. In decode mode it happens after `out_eos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Port active; low means idle |
| dec_mode | input | 1 | 1 = decode (output) mode, 0 = encode (input) mode |
| cfg_busy | input | 1 | Configuration being read or processed |
| comp_blocks | input | 12 | Block count per component, 3 bits each |
| buf_full | input | 1 | Coefficient buffers full |
| in_sync | input | 1 | Encode block sync, one cycle before sample 0 |
| in_eos | input | 1 | Encode end of scan, with the last sample |
| enc_stop | output | 1 | Encode-side stop toward the sender |
| sync_err | output | 1 | Sync arrived inside an incomplete block |
| dec_start | input | 1 | Start a decode scan |
| dec_nblk | input | 8 | Blocks in the decode scan |
| ext_stop | input | 1 | External stop from the receiver in decode mode |
| out_sync | output | 1 | Decode block sync, one cycle before sample 0 |
| out_valid | output | 1 | Decode sample present |
| out_eos | output | 1 | Decode last sample of the scan |
| comp_tag | output | 2 | Component of the current block, 11 when idle |

## Verification
Every output of this block is registered. `enc_stop`, `sync_err` and `comp_tag` respond one cycle after the edge that samples the causing input. `out_sync` follows `dec_start` by one cycle, and the first `out_valid` follows `out_sync` by one cycle. After the stop is released, the restart sync lands 17 cycles after the first low cycle of `ext_stop`. The bench drives inputs and samples outputs on the falling edge. It counts cycles from the sync to the exact sample index where each response is due, and checks both the cycle before and the cycle of that response.

// File: rtl/blkstream_pkg.sv
package blkstream_pkg;

    localparam int NCOMP = 4;

    typedef logic [1:0] comp_tag_t;

    localparam comp_tag_t TAG_IDLE = 2'b11;

    typedef struct packed {
        logic sync;
        logic eos;
    } frame_evt_t;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_SYNC,
        DS_DATA,
        DS_HOLD,
        DS_GAP
    } dec_state_e;

    // Next present component after cur, searching cyclically; cur itself last.
    function automatic comp_tag_t next_comp(comp_tag_t cur, logic [NCOMP-1:0] present);
        comp_tag_t r;
        r = cur;
        for (int k = NCOMP; k >= 1; k--) begin
            int j;
            j = (int'(cur) + k) % NCOMP;
            if (present[j]) r = comp_tag_t'(j);
        end
        return r;
    endfunction

endpackage

// File: rtl/blkstream_enc.sv
module blkstream_enc
    import blkstream_pkg::*;
#(
    parameter int BLK_LEN = 64,
    parameter int LEAD    = 42
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       dec_mode,
    input  logic       cfg_busy,
    input  logic       buf_full,
    input  logic       in_sync,
    input  logic       in_eos,
    output logic       enc_stop,
    output logic       sync_err,
    output frame_evt_t evt
);

    localparam int IDX_W = $clog2(BLK_LEN);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(BLK_LEN - 1);
    localparam logic [IDX_W-1:0] ARM_IDX = IDX_W'(BLK_LEN - 1 - LEAD - 1);

    logic             en;
    logic             active;
    logic [IDX_W-1:0] idx;
    logic             hold;
    logic             hold_nx;
    logic             stop_q;
    logic             err_q;

    assign en = run && !dec_mode;

    always_comb begin
        hold_nx = buf_full && !dec_mode && ((active && idx == ARM_IDX) || hold);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            hold   <= 1'b0;
            stop_q <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            err_q <= en && in_sync && active && (idx != LAST);
            if (en && in_sync) begin
                active <= 1'b1;
                idx    <= '0;
            end else if (active) begin
                if (idx == LAST) active <= 1'b0;
                else             idx    <= idx + IDX_W'(1);
            end
            hold   <= hold_nx;
            stop_q <= !dec_mode && (!run || cfg_busy || hold_nx);
        end
    end

    assign enc_stop = stop_q;
    assign sync_err = err_q;
    assign evt.sync = en && in_sync;
    assign evt.eos  = en && in_eos;

    // R1: an accepted sync opens a block at sample index 0
    assert_sync_opens_block_R1: assert property (@(posedge clk) disable iff (rst)
        (en && in_sync) |=> (active && idx == '0));

    // R2: full buffers at the arming sample raise the stop
    assert_stop_lead_R2: assert property (@(posedge clk) disable iff (rst)
        (!dec_mode && active && idx == ARM_IDX && buf_full) |=> enc_stop);

    // R4: idle or configuration work keeps the stop high
    assert_idle_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (!dec_mode && (!run || cfg_busy)) |=> enc_stop);

    // R4: never a stop in decode mode
    assert_dec_no_stop_R4: assert property (@(posedge clk) disable iff (rst)
        dec_mode |=> !enc_stop);

endmodule

// File: rtl/blkstream_dec.sv
module blkstream_dec
    import blkstream_pkg::*;
#(
    parameter int BLK_LEN = 64,
    parameter int SETUP   = 24,
    parameter int GAP     = 17,
    parameter int NBLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic [NBLK_W-1:0] nblk,
    input  logic              ext_stop,
    output logic              out_sync,
    output logic              out_valid,
    output logic              out_eos
);

    localparam int IDX_W = $clog2(BLK_LEN);
    localparam int GAP_W = $clog2(GAP);
    localparam logic [IDX_W-1:0] LAST      = IDX_W'(BLK_LEN - 1);
    localparam logic [IDX_W-1:0] SETUP_IDX = IDX_W'(BLK_LEN - 1 - SETUP);
    localparam logic [GAP_W-1:0] GAP_END   = GAP_W'(GAP - 2);

    dec_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [GAP_W-1:0]  gcnt;
    logic [NBLK_W-1:0] blk_cnt;
    logic [NBLK_W-1:0] nblk_eff;
    logic              stop_req;
    logic              last_blk;

    assign nblk_eff = (nblk == '0) ? NBLK_W'(1) : nblk;
    assign last_blk = (blk_cnt >= nblk_eff);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state    <= DS_IDLE;
            idx      <= '0;
            gcnt     <= '0;
            blk_cnt  <= '0;
            stop_req <= 1'b0;
        end else begin
            case (state)
                DS_IDLE: begin
                    if (start) begin
                        state   <= DS_SYNC;
                        blk_cnt <= '0;
                    end
                end
                DS_SYNC: begin
                    state    <= DS_DATA;
                    idx      <= '0;
                    blk_cnt  <= blk_cnt + NBLK_W'(1);
                    stop_req <= 1'b0;
                end
                DS_DATA: begin
                    if (idx == SETUP_IDX && ext_stop) stop_req <= 1'b1;
                    if (idx == LAST) begin
                        if (last_blk)      state <= DS_IDLE;
                        else if (stop_req) state <= DS_HOLD;
                        else               state <= DS_SYNC;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                DS_HOLD: begin
                    if (!ext_stop) begin
                        state <= DS_GAP;
                        gcnt  <= '0;
                    end
                end
                DS_GAP: begin
                    if (gcnt == GAP_END) state <= DS_SYNC;
                    else                 gcnt  <= gcnt + GAP_W'(1);
                end
                default: state <= DS_IDLE;
            endcase
        end
    end

    assign out_sync  = (state == DS_SYNC);
    assign out_valid = (state == DS_DATA);
    assign out_eos   = (state == DS_DATA) && (idx == LAST) && last_blk;

    // R5: a sync is one cycle wide and precedes sample 0
    assert_sync_then_data_R5: assert property (@(posedge clk) disable iff (rst)
        (out_sync && en) |=> (out_valid && !out_sync));

    // R6: no sync while parked on a held stop
    assert_hold_no_sync_R6: assert property (@(posedge clk) disable iff (rst)
        (state == DS_HOLD && ext_stop) |=> !out_sync);

    // R7: end of scan is never followed by a sync
    assert_eos_no_sync_R7: assert property (@(posedge clk) disable iff (rst)
        out_eos |=> !out_sync);

endmodule

// File: rtl/blkstream_tagger.sv
module blkstream_tagger
    import blkstream_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  frame_evt_t             evt,
    input  logic [NCOMP*CNT_W-1:0] comp_blocks,
    output comp_tag_t              comp_tag
);

    typedef struct packed {
        comp_tag_t        comp;
        logic [CNT_W-1:0] n;
    } tag_pos_t;

    logic [NCOMP-1:0] present;
    comp_tag_t        first;
    tag_pos_t         pos;
    comp_tag_t        tag_q;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W:0]   nplus;
    logic             adv;

    for (genvar i = 0; i < NCOMP; i++) begin : g_present
        assign present[i] = (comp_blocks[i*CNT_W +: CNT_W] != '0);
    end

    assign first   = next_comp(TAG_IDLE, present);
    assign cur_cnt = comp_blocks[int'(pos.comp)*CNT_W +: CNT_W];
    assign nplus   = {1'b0, pos.n} + (CNT_W+1)'(1);
    assign adv     = (nplus >= {1'b0, cur_cnt});

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= TAG_IDLE;
            pos   <= '0;
        end else if (!run) begin
            tag_q    <= TAG_IDLE;
            pos.comp <= first;
            pos.n    <= '0;
        end else if (evt.sync) begin
            tag_q <= pos.comp;
            if (adv) begin
                pos.comp <= next_comp(pos.comp, present);
                pos.n    <= '0;
            end else begin
                pos.n <= pos.n + CNT_W'(1);
            end
        end else if (evt.eos) begin
            tag_q    <= TAG_IDLE;
            pos.comp <= first;
            pos.n    <= '0;
        end
    end

    assign comp_tag = tag_q;

    // R9: idle forces the idle tag
    assert_idle_tag_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (comp_tag == TAG_IDLE));

    // R10: end of scan without a new sync shows the idle tag
    assert_eos_tag_R10: assert property (@(posedge clk) disable iff (rst)
        (run && evt.eos && !evt.sync) |=> (comp_tag == TAG_IDLE));

endmodule

// File: rtl/blkstream_flow.sv
module blkstream_flow
    import blkstream_pkg::*;
#(
    parameter int BLK_LEN = 64,
    parameter int LEAD    = 42,
    parameter int SETUP   = 24,
    parameter int GAP     = 17,
    parameter int NBLK_W  = 8,
    parameter int CNT_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic                   dec_mode,
    input  logic                   cfg_busy,
    input  logic [4*CNT_W-1:0]     comp_blocks,
    input  logic                   buf_full,
    input  logic                   in_sync,
    input  logic                   in_eos,
    output logic                   enc_stop,
    output logic                   sync_err,
    input  logic                   dec_start,
    input  logic [NBLK_W-1:0]      dec_nblk,
    input  logic                   ext_stop,
    output logic                   out_sync,
    output logic                   out_valid,
    output logic                   out_eos,
    output logic [1:0]             comp_tag
);

    frame_evt_t enc_evt;
    frame_evt_t dec_evt;
    frame_evt_t tag_evt;
    comp_tag_t  tag_w;

    blkstream_enc #(.BLK_LEN(BLK_LEN), .LEAD(LEAD)) u_enc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .dec_mode (dec_mode),
        .cfg_busy (cfg_busy),
        .buf_full (buf_full),
        .in_sync  (in_sync),
        .in_eos   (in_eos),
        .enc_stop (enc_stop),
        .sync_err (sync_err),
        .evt      (enc_evt)
    );

    blkstream_dec #(.BLK_LEN(BLK_LEN), .SETUP(SETUP), .GAP(GAP), .NBLK_W(NBLK_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .en        (run && dec_mode),
        .start     (dec_start),
        .nblk      (dec_nblk),
        .ext_stop  (ext_stop),
        .out_sync  (out_sync),
        .out_valid (out_valid),
        .out_eos   (out_eos)
    );

    assign dec_evt.sync = out_sync;
    assign dec_evt.eos  = out_eos;
    assign tag_evt      = dec_mode ? dec_evt : enc_evt;

    blkstream_tagger #(.CNT_W(CNT_W)) u_tag (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .evt         (tag_evt),
        .comp_blocks (comp_blocks),
        .comp_tag    (tag_w)
    );

    assign comp_tag = tag_w;

endmodule

// File: tb/blkstream_flow_bench.sv
`timescale 1ns/1ps
module blkstream_flow_bench;

    logic        clk = 1'b0;
    logic        rst, run, dec_mode, cfg_busy, buf_full, in_sync, in_eos;
    logic        dec_start, ext_stop;
    logic [11:0] comp_blocks;
    logic [7:0]  dec_nblk;
    logic        enc_stop, sync_err, out_sync, out_valid, out_eos;
    logic [1:0]  comp_tag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    blkstream_flow u_blkstream_flow (
        .clk(clk), .rst(rst), .run(run), .dec_mode(dec_mode), .cfg_busy(cfg_busy),
        .comp_blocks(comp_blocks), .buf_full(buf_full), .in_sync(in_sync), .in_eos(in_eos),
        .enc_stop(enc_stop), .sync_err(sync_err), .dec_start(dec_start), .dec_nblk(dec_nblk),
        .ext_stop(ext_stop), .out_sync(out_sync), .out_valid(out_valid), .out_eos(out_eos),
        .comp_tag(comp_tag)
    );

    // {comp_blocks, six expected tags packed two bits each, first sync in bits [1:0]}
    localparam logic [23:0] TAG_VEC [4] = '{
        {12'h249, 12'h4E4},
        {12'h04C, 12'h900},
        {12'h0C2, 12'h2A0},
        {12'h400, 12'hFFF}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int bad;
        rst = 1; run = 0; dec_mode = 0; cfg_busy = 0; buf_full = 0; in_sync = 0;
        in_eos = 0; dec_start = 0; ext_stop = 0; comp_blocks = 12'h249; dec_nblk = 8'd1;
        repeat (3) step();
        // reset state
        chk("reset enc_stop R4", int'(enc_stop), 1);
        chk("reset comp_tag R9", int'(comp_tag), 3);
        chk("reset out_sync R5", int'(out_sync), 0);
        chk("reset sync_err R1", int'(sync_err), 0);
        rst = 0;
        step();

        // R8: component pattern table walk (encode syncs, back-to-back blocks)
        for (int e = 0; e < 4; e++) begin
            comp_blocks = TAG_VEC[e][23:12];
            run = 0;
            step();
            run = 1;
            for (int k = 0; k < 6; k++) begin
                in_sync = 1;
                step();
                in_sync = 0;
                chk($sformatf("R8 entry %0d sync %0d tag", e, k), int'(comp_tag),
                    int'(TAG_VEC[e][2*k +: 2]));
                chk("R1 sync on last sample no error", int'(sync_err), 0);
                repeat (63) step();
            end
            step();
        end

        // R1: sync cutting a block short
        comp_blocks = 12'h249;
        run = 0; step(); run = 1;
        in_sync = 1; step(); in_sync = 0;
        repeat (10) step();
        in_sync = 1; step(); in_sync = 0;
        chk("R1 early sync error", int'(sync_err), 1);
        step();
        chk("R1 error one cycle", int'(sync_err), 0);
        repeat (62) step();
        step();

        // R2 + R10: stop lead and end of scan under stop
        buf_full = 1;
        in_sync = 1; step(); in_sync = 0;
        chk("R8 third component tag", int'(comp_tag), 2);
        repeat (20) step();
        chk("R2 stop low at sample 20", int'(enc_stop), 0);
        step();
        chk("R2 stop high at sample 21", int'(enc_stop), 1);
        repeat (42) step();
        chk("R2 stop held at sample 63", int'(enc_stop), 1);
        in_eos = 1; step(); in_eos = 0;
        chk("R10 eos under stop gives idle tag", int'(comp_tag), 3);
        buf_full = 0; step();
        chk("R2 stop drops after buf_full low", int'(enc_stop), 0);

        // R3: late buffer-full has no effect on this block
        in_sync = 1; step(); in_sync = 0;
        repeat (29) step();
        buf_full = 1;
        bad = 0;
        for (int i = 0; i < 35; i++) begin
            step();
            if (enc_stop) bad++;
        end
        chk("R3 late buf_full stop cycles", bad, 0);
        buf_full = 0; step();

        // R4 / R9
        cfg_busy = 1; step();
        chk("R4 stop while cfg_busy", int'(enc_stop), 1);
        cfg_busy = 0; step();
        chk("R4 stop clears", int'(enc_stop), 0);
        run = 0; step();
        chk("R4 stop while idle", int'(enc_stop), 1);
        chk("R9 idle tag", int'(comp_tag), 3);
        dec_mode = 1; step();
        chk("R4 no stop in decode", int'(enc_stop), 0);

        // R5 / R7: two decode blocks
        run = 1; dec_nblk = 8'd2; step();
        dec_start = 1; step(); dec_start = 0;
        chk("R5 sync after start", int'(out_sync), 1);
        step();
        chk("R5 sample 0 valid", int'(out_valid), 1);
        chk("R5 sync one cycle", int'(out_sync), 0);
        chk("R8 decode first tag", int'(comp_tag), 0);
        bad = 0;
        for (int i = 0; i < 63; i++) begin
            step();
            if (!out_valid || out_sync) bad++;
        end
        chk("R5 64 valid samples", bad, 0);
        chk("R7 no eos on first block", int'(out_eos), 0);
        step();
        chk("R5 back-to-back sync", int'(out_sync), 1);
        step();
        chk("R8 decode second tag", int'(comp_tag), 1);
        repeat (63) step();
        chk("R7 eos on last sample", int'(out_eos), 1);
        step();
        chk("R7 no sync after eos", int'(out_sync), 0);
        chk("R7 no valid after eos", int'(out_valid), 0);
        chk("R10 decode eos idle tag", int'(comp_tag), 3);

        // R6: stop at sample 39, then late stop at sample 40
        dec_nblk = 8'd3;
        dec_start = 1; step(); dec_start = 0;
        step();
        repeat (39) step();
        ext_stop = 1;
        repeat (24) step();
        step();
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            if (out_sync) bad++;
            step();
        end
        chk("R6 no sync while stop held", bad, 0);
        ext_stop = 0;
        repeat (16) step();
        chk("R6 no sync at 16 after release", int'(out_sync), 0);
        step();
        chk("R6 sync 17 after release", int'(out_sync), 1);
        step();
        repeat (40) step();
        ext_stop = 1;
        repeat (23) step();
        step();
        chk("R6 late stop ignored", int'(out_sync), 1);
        ext_stop = 0;
        step();
        repeat (63) step();
        chk("R7 eos third block", int'(out_eos), 1);
        step();

        // R7: zero block count means one block
        dec_nblk = 8'd0;
        dec_start = 1; step(); dec_start = 0;
        step();
        repeat (63) step();
        chk("R7 count zero gives one block", int'(out_eos), 1);
        step();
        chk("R7 count zero no second sync", int'(out_sync), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule